// File: doc/BRIEF.md
# Three-Wire Serial Register-Access Master

This block is the host end of a half-duplex control port built from a serial clock, an active-low select and one shared data line. A request carries an 8-bit register address, a direction flag and a 16-bit write value. The block turns each accepted request into one framed transfer. It first sends a 9-bit header in which the direction bit sits between the upper three address bits and the lower five. It then either drives 16 data bits or hands the line to the device and collects 16 returned bits. A one-cycle done pulse ends the transfer, and the read value stays in a register.

The serial clock is derived from the system clock. A parameter sets its half-period, and elaboration-time checks reject any setting that would exceed the device's clock rate or shorten a phase below its minimum. The shared line is modelled at the pad as a separate output, an output enable and an input.

The block also controls the device reset output. While the reset request is high, the output is held low. After the request drops, the output is released only once a quiet window has passed with no rising serial clock edge. This protects the device's interface-mode selection, which is latched at reset release.

Top module: `tw_reg_master`

## Requirements
- R1: Every serial clock high phase, and every low phase between two rising edges, lasts exactly HALF_DIV system clock cycles.
- R2: Each transfer has exactly 25 rising serial clock edges. The first 9 carry the header most significant bit first: address bits 7, 6, 5, then the direction bit (1 = read, 0 = write), then address bits 4 down to 0.
- R3: On a write, rising edges 10 to 25 carry the write value, bit 15 first. The data output changes only on falling serial clock edges, so it is stable while the clock is high.
- R4: On a read, the output enable drops on the falling edge after the 9th rising edge and stays low until the end of the transfer. The block captures the data input on the falling edge after each of rising edges 10 to 25, and the first captured bit becomes bit 15 of the read data.
- R5: The select falls HALF_DIV cycles before the first rising edge and rises HALF_DIV cycles after the last falling edge. The serial clock is low whenever the select is high.
- R6: busy is high from the cycle after a request is accepted until done. A request made while busy is high is ignored.
- R7: done is a single-cycle pulse and busy is low during it. A read updates the read data when done pulses. A write leaves the read data unchanged.
- R8: The device reset output is low while the reset request is high. It rises only after the request is low and at least QUIET_CYC system cycles have passed since the last rising serial clock edge, or since system reset.
- R9: A request made while the device reset output is low is ignored.
- R10: During system reset, select is high, the serial clock is low, the output enable is low, busy and done are low, and the device reset output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| req_valid | input | 1 | Request strobe, taken when idle and device reset released |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read value |
| dev_rst_req | input | 1 | Request to hold the device in reset |
| dev_rst_n | output | 1 | Active-low device reset |
| sclk | output | 1 | Serial clock |
| sen_n | output | 1 | Active-low select |
| sdio_o | output | 1 | Data line output value |
| sdio_oe | output | 1 | Data line output enable |
| sdio_i | input | 1 | Data line input value |

## Verification
The assertions assume that req_valid, the request fields, sdio_i and dev_rst_req are synchronous to clk, and that sdio_i already holds the device's bit by the falling serial edge that follows each rising edge. The bench's device model meets both conditions. It changes every input only on the falling system clock edge, and it places each returned bit on sdio_i one system cycle after it sees the matching rising serial edge, so the bit is ready a full half-period before the block samples it. The bench raises the reset request in the middle of a read, while serial clock edges are still arriving, so the quiet-window rule is tested against live edges.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LEAD = 2'd1,
      ST_HIGH = 2'd2,
      ST_LOW  = 2'd3
   } tw_state_e;
endpackage

// File: rtl/tw_half_tick.sv
module tw_half_tick #(
   parameter int HALF_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clr)           cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick = !clr && (cnt_q == LAST);
endmodule

// File: rtl/tw_reset_gate.sv
module tw_reset_gate #(
   parameter int QUIET_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rst_req,
   input  logic rise_evt,
   output logic dev_rst_n
);
   localparam int QW = $clog2(QUIET_CYC + 2);
   localparam logic [QW-1:0] QLIM = QW'(QUIET_CYC);

   logic [QW-1:0] quiet_q;
   logic          rel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              quiet_q <= '0;
      else if (rise_evt)       quiet_q <= '0;
      else if (quiet_q < QLIM) quiet_q <= quiet_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      rel_q <= 1'b0;
      else if (rst_req)                                rel_q <= 1'b0;
      else if (!rel_q && quiet_q == QLIM && !rise_evt) rel_q <= 1'b1;
   end

   assign dev_rst_n = rel_q;

   AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rel_q); // R8
endmodule

// File: rtl/tw_engine.sv
module tw_engine
   import tw_pkg::*;
#(
   parameter int   ADDR_W  = 8,
   parameter int   DATA_W  = 16,
   parameter int   RW_SLOT = 3,
   parameter logic RD_FLAG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              sdio_i,
   output logic              tick_clr,
   output logic              rise_evt,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              sclk,
   output logic              sen_n,
   output logic              sdio_o,
   output logic              sdio_oe
);
   localparam int HDR_W   = ADDR_W + 1;
   localparam int FRAME_W = HDR_W + DATA_W;
   localparam int LO_BITS = ADDR_W - RW_SLOT;
   localparam int K_W     = $clog2(FRAME_W + 1);
   localparam logic [K_W-1:0] K_END        = K_W'(FRAME_W);
   localparam logic [K_W-1:0] K_HDR_LAST   = K_W'(HDR_W - 1);
   localparam logic [K_W-1:0] K_DATA_FIRST = K_W'(HDR_W);

   tw_state_e          state_q;
   logic [K_W-1:0]     k_q;
   logic [FRAME_W-1:0] tx_q;
   logic [DATA_W-1:0]  rx_q;
   logic [DATA_W-1:0]  rdata_q;
   logic               rd_q, sclk_q, sen_q, oe_q, done_q;
   logic [HDR_W-1:0]   hdr;
   logic               accept;

   // Header: upper address bits, then direction, then lower address bits.
   for (genvar gi = 0; gi < HDR_W; gi++) begin : g_hdr
      if (gi == LO_BITS) begin : g_flag
         assign hdr[gi] = req_write ? ~RD_FLAG : RD_FLAG;
      end else if (gi < LO_BITS) begin : g_lo
         assign hdr[gi] = req_addr[gi];
      end else begin : g_hi
         assign hdr[gi] = req_addr[gi-1];
      end
   end

   assign accept   = (state_q == ST_IDLE) && start;
   assign tick_clr = (state_q == ST_IDLE);
   assign rise_evt = tick && ((state_q == ST_LEAD) ||
                              ((state_q == ST_LOW) && (k_q != K_END)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         k_q     <= '0;
         tx_q    <= '0;
         rx_q    <= '0;
         rdata_q <= '0;
         rd_q    <= 1'b0;
         sclk_q  <= 1'b0;
         sen_q   <= 1'b1;
         oe_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  tx_q    <= {hdr, req_wdata};
                  k_q     <= '0;
                  rd_q    <= !req_write;
                  sen_q   <= 1'b0;
                  oe_q    <= 1'b1;
                  sclk_q  <= 1'b0;
                  state_q <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (tick) begin
                  sclk_q  <= 1'b1;
                  state_q <= ST_HIGH;
               end
            end
            ST_HIGH: begin
               if (tick) begin
                  sclk_q  <= 1'b0;
                  k_q     <= k_q + 1'b1;
                  tx_q    <= {tx_q[FRAME_W-2:0], 1'b0};
                  if (rd_q && k_q >= K_DATA_FIRST)
                     rx_q <= {rx_q[DATA_W-2:0], sdio_i};
                  if (rd_q && k_q == K_HDR_LAST)
                     oe_q <= 1'b0;
                  state_q <= ST_LOW;
               end
            end
            ST_LOW: begin
               if (tick) begin
                  if (k_q == K_END) begin
                     sen_q   <= 1'b1;
                     oe_q    <= 1'b0;
                     done_q  <= 1'b1;
                     if (rd_q) rdata_q <= rx_q;
                     state_q <= ST_IDLE;
                  end else begin
                     sclk_q  <= 1'b1;
                     state_q <= ST_HIGH;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign done    = done_q;
   assign rdata   = rdata_q;
   assign sclk    = sclk_q;
   assign sen_n   = sen_q;
   assign sdio_o  = tx_q[FRAME_W-1];
   assign sdio_oe = oe_q;

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      sen_q |-> !sclk_q); // R5
   AST_SDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_q && $past(sclk_q)) |-> $stable(tx_q[FRAME_W-1])); // R3
   AST_OE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q && state_q != ST_IDLE && k_q > K_HDR_LAST) |-> !oe_q); // R4
   AST_RISE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      k_q <= K_END); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy); // R7
   AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_q); // R6
endmodule

// File: rtl/tw_reg_master.sv
module tw_reg_master #(
   parameter longint SYS_CLK_HZ = 50_000_000,
   parameter int     HALF_DIV   = 10,
   parameter int     QUIET_CYC  = 16,
   parameter int     ADDR_W     = 8,
   parameter int     DATA_W     = 16,
   parameter int     RW_SLOT    = 3,
   parameter logic   RD_FLAG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   input  logic              dev_rst_req,
   output logic              dev_rst_n,
   output logic              sclk,
   output logic              sen_n,
   output logic              sdio_o,
   output logic              sdio_oe,
   input  logic              sdio_i
);
   localparam longint MAX_SCLK_HZ  = 2_500_000;
   localparam longint MIN_PHASE_NS = 25;
   localparam longint QUIET_NS     = 300;
   localparam longint NS_PER_S     = 1_000_000_000;
   localparam int     GW           = $clog2(QUIET_CYC + 2);
   localparam logic [GW-1:0] GLIM  = GW'(QUIET_CYC);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end
   if (2 * longint'(HALF_DIV) * MAX_SCLK_HZ < SYS_CLK_HZ) begin : g_bad_rate
      $error("serial clock would exceed its maximum rate");
   end
   if (longint'(HALF_DIV) * NS_PER_S < MIN_PHASE_NS * SYS_CLK_HZ) begin : g_bad_phase
      $error("serial clock phase shorter than minimum");
   end
   if (longint'(QUIET_CYC) * NS_PER_S < QUIET_NS * SYS_CLK_HZ) begin : g_bad_quiet
      $error("QUIET_CYC too short for the reset quiet window");
   end
   if (RW_SLOT < 0 || RW_SLOT > ADDR_W || DATA_W < 2) begin : g_bad_fmt
      $error("illegal frame format parameters");
   end

   logic tick, tick_clr, rise_evt;

   tw_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tick_clr),
      .tick  (tick)
   );

   tw_reset_gate #(.QUIET_CYC(QUIET_CYC)) u_rgate (
      .clk       (clk),
      .rst_n     (rst_n),
      .rst_req   (dev_rst_req),
      .rise_evt  (rise_evt),
      .dev_rst_n (dev_rst_n)
   );

   tw_engine #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .RW_SLOT (RW_SLOT),
      .RD_FLAG (RD_FLAG)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .start     (req_valid && dev_rst_n),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .sdio_i    (sdio_i),
      .tick_clr  (tick_clr),
      .rise_evt  (rise_evt),
      .busy      (busy),
      .done      (done),
      .rdata     (rdata),
      .sclk      (sclk),
      .sen_n     (sen_n),
      .sdio_o    (sdio_o),
      .sdio_oe   (sdio_oe)
   );

   // Cycles since the sclk port was last seen rising, for the quiet-window check.
   logic          sclk_prev_q;
   logic [GW-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev_q <= 1'b0;
         gap_q       <= '0;
      end else begin
         sclk_prev_q <= sclk;
         if (sclk && !sclk_prev_q) gap_q <= '0;
         else if (gap_q < GLIM)    gap_q <= gap_q + 1'b1;
      end
   end

   AST_QUIET_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_rst_n) |-> (gap_q >= GLIM)); // R8
   AST_NO_START_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (!dev_rst_n && !busy) |=> !busy); // R9
endmodule

// File: tb/tw_reg_master_tb.sv
module tw_reg_master_tb;
   localparam int CLK_PERIOD = 20;
   localparam int H          = 10;
   localparam int QUIET      = 16;

   typedef struct {
      bit          wr;
      logic [7:0]  addr;
      logic [15:0] data;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        dev_rst_req = 1'b0;
   logic        sdio_i = 1'b0;
   logic        busy, done, dev_rst_n, sclk, sen_n, sdio_o, sdio_oe;
   logic [15:0] rdata;

   int total = 0, bad = 0;
   item_t       frame_q[$];
   logic [15:0] rexp_q[$];
   logic [15:0] dev_mem[256];
   logic [15:0] ref_mem[256];
   logic [15:0] last_rd = '0;
   int frames_seen = 0, frames_pushed = 0, idle_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tw_reg_master u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .rdata(rdata), .dev_rst_req(dev_rst_req), .dev_rst_n(dev_rst_n),
      .sclk(sclk), .sen_n(sen_n), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
      .sdio_i(sdio_i)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // Monitor: device model and scoreboard side.
   int cyc = 0, nrise = 0, last_edge = 0, last_fall = 0, last_rise = 0;
   logic       prev_sclk = 1'b0, prev_sen = 1'b1, prev_done = 1'b0, prev_rel = 1'b0;
   logic [8:0] hdr;
   logic [15:0] dat;
   int phase_bad = 0, lead_len = 0, oe_bad = 0;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) last_rise = cyc;
      if (sen_n && sclk) idle_bad++;
      if (!sen_n && prev_sen) begin
         nrise = 0; hdr = '0; dat = '0; last_edge = cyc;
         phase_bad = 0; oe_bad = 0; lead_len = 0;
      end
      if (!sen_n) begin
         if (sclk && !prev_sclk) begin
            nrise++;
            if (nrise == 1) lead_len = cyc - last_edge;
            else if (cyc - last_edge != H) phase_bad++;
            last_edge = cyc; last_rise = cyc;
            if (nrise <= 9) begin
               hdr = {hdr[7:0], sdio_o};
               if (!sdio_oe) oe_bad++;
            end else if (hdr[5] == 1'b0) begin
               dat = {dat[14:0], sdio_o};
               if (!sdio_oe) oe_bad++;
            end else begin
               if (sdio_oe) oe_bad++;
               sdio_i = dev_mem[{hdr[8:6], hdr[4:0]}][25-nrise];
            end
         end
         if (!sclk && prev_sclk) begin
            if (cyc - last_edge != H) phase_bad++;
            last_edge = cyc; last_fall = cyc;
         end
      end
      if (sen_n && !prev_sen) begin
         item_t it;
         frames_seen++;
         chk(phase_bad == 0, "R1 phase length", phase_bad, 0);
         chk(lead_len == H && (cyc - last_fall) == H, "R5 select lead/tail",
             lead_len, H);
         chk(nrise == 25, "R2 rising edge count", nrise, 25);
         chk(oe_bad == 0, "R4 output enable direction", oe_bad, 0);
         if (frame_q.size() == 0) begin
            chk(1'b0, "R6 unexpected frame", frames_seen, frames_pushed);
         end else begin
            it = frame_q.pop_front();
            chk(hdr == {it.addr[7:5], ~it.wr, it.addr[4:0]}, "R2 header",
                hdr, {it.addr[7:5], ~it.wr, it.addr[4:0]});
            if (it.wr) begin
               chk(dat == it.data, "R3 write data", dat, it.data);
               dev_mem[{hdr[8:6], hdr[4:0]}] = dat;
            end
         end
      end
      if (dev_rst_n && !prev_rel)
         chk((cyc - last_rise) >= QUIET, "R8 quiet window", cyc - last_rise, QUIET);
      if (done) begin
         chk(!busy, "R7 busy low at done", busy, 0);
         if (rexp_q.size() != 0) begin
            logic [15:0] e;
            e = rexp_q.pop_front();
            chk(rdata == e, "R4 R7 read data", rdata, e);
         end
      end
      if (done && prev_done) chk(1'b0, "R7 done pulse width", 2, 1);
      prev_sclk = sclk; prev_sen = sen_n; prev_done = done; prev_rel = dev_rst_n;
   end

   task automatic do_xfer(input bit wr, input logic [7:0] a, input logic [15:0] d);
      item_t it;
      while (busy || !dev_rst_n) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      it.wr = wr; it.addr = a; it.data = d;
      frame_q.push_back(it);
      frames_pushed++;
      if (wr) ref_mem[a] = d;
      else    last_rd = ref_mem[a];
      rexp_q.push_back(last_rd);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy, "R6 busy after accept", busy, 1);
   endtask

   task automatic wait_idle();
      while (busy || frame_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (CLK_PERIOD * 7500) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         dev_mem[i] = 16'h3C5A ^ {i[7:0], ~i[7:0]};
         ref_mem[i] = 16'h3C5A ^ {i[7:0], ~i[7:0]};
      end
      repeat (4) @(negedge clk);
      chk(sen_n && !sclk && !sdio_oe && !busy && !done && !dev_rst_n,
          "R10 reset state", {sen_n, sclk, sdio_oe, busy, done, dev_rst_n}, 6'b100000);
      rst_n = 1'b1;
      // R9: request while device reset output still low
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h11; req_wdata = 16'hDEAD;
      repeat (3) @(negedge clk);
      chk(!busy && !dev_rst_n, "R9 request ignored in reset", busy, 0);
      req_valid = 1'b0;
      while (!dev_rst_n) @(negedge clk);
      chk(frames_seen == 0 && !busy, "R9 no frame in reset", frames_seen, 0);

      do_xfer(1'b1, 8'hA5, 16'h1234);
      do_xfer(1'b1, 8'h00, 16'hFFFF);
      do_xfer(1'b1, 8'hFF, 16'h0000);
      do_xfer(1'b0, 8'hA5, 16'h0);
      do_xfer(1'b0, 8'h00, 16'h0);
      do_xfer(1'b0, 8'hFF, 16'h0);
      do_xfer(1'b0, 8'h20, 16'h0);
      do_xfer(1'b1, 8'h80, 16'h8001);
      do_xfer(1'b1, 8'h1F, 16'h5AA5);
      do_xfer(1'b0, 8'h1F, 16'h0);
      wait_idle();

      // R6: request while busy is ignored
      do_xfer(1'b1, 8'h42, 16'hC3C3);
      repeat (30) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h33; req_wdata = 16'h7777;
      repeat (4) @(negedge clk);
      req_valid = 1'b0;
      chk(busy, "R6 still busy", busy, 1);
      wait_idle();
      chk(frames_seen == frames_pushed, "R6 frames match", frames_seen, frames_pushed);
      do_xfer(1'b0, 8'h33, 16'h0);
      do_xfer(1'b0, 8'h42, 16'h0);
      wait_idle();

      // R7: write leaves rdata unchanged
      do_xfer(1'b1, 8'h42, 16'h0F0F);
      wait_idle();
      chk(rdata == last_rd, "R7 rdata kept on write", rdata, last_rd);

      // R8: reset request during a live read
      do_xfer(1'b0, 8'h0F, 16'h0);
      repeat (100) @(negedge clk);
      dev_rst_req = 1'b1;
      repeat (5) @(negedge clk);
      chk(!dev_rst_n, "R8 reset held", dev_rst_n, 0);
      dev_rst_req = 1'b0;
      wait_idle();
      while (!dev_rst_n) @(negedge clk);
      do_xfer(1'b0, 8'h80, 16'h0);
      wait_idle();

      chk(idle_bad == 0, "R5 clock low while deselected", idle_bad, 0);
      chk(frames_seen == frames_pushed, "R2 total frames", frames_seen, frames_pushed);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule